// File: doc/BRIEF.md
# Half-Bridge Fault and Frequency-Limit Supervisor

This block decides, clock by clock, whether the gate drivers of a resonant half-bridge may switch. Its inputs are digitized comparator flags and a one-clock strobe that marks the end of each switching cycle. The flags are a high-level overcurrent flag, a lower-level overcurrent flag, and a flag that says the commanded frequency has reached its ceiling. Its outputs are a gate-enable, a latched fault-shutdown flag and a soft-start flag. The soft-start flag also tells the oscillator to force its frequency command to the top of its range.

A high-level overcurrent removes gate drive at once, with no wait for a cycle boundary. A low-level overcurrent causes a trip only when it has been present in eight switching cycles in a row. Both trips latch a shutdown that holds until the global enable is dropped and raised again. Every start from enable runs a counted soft-start before normal regulation. When the frequency ceiling is reached, gating is suppressed for whole cycles only. The decision is sampled at each cycle strobe.

The block has no data stream, so every pin is a plain level or strobe with no handshake. All control pins are synchronous to `clk`. `rst_n` is an active-low asynchronous reset.

Top module: `hb_guard`

## Requirements
- R1: While reset is asserted or `enable` is low, `gate_en`, `fault_shdn` and `ss_active` are all 0, and `oc_fast` or `oc_slow` cause no fault.
- R2: When `enable` is high in the off state, `ss_active` and `gate_en` are 1 from the next clock edge. `ss_active` stays 1 for exactly `SS_CYCLES` strobes of `cyc_start` and falls at the edge of the last of them (default 4096).
- R3: During soft-start, `f_at_max` has no effect: `gate_en` stays 1.
- R4: In normal running, `f_at_max` is sampled only on clock edges where `cyc_start` is 1. From that edge until the next strobe edge, `gate_en` equals the inverse of the sampled value. Changes of `f_at_max` between strobes do nothing.
- R5: During soft-start or running, `oc_fast` = 1 forces `gate_en` to 0 in the same clock, combinationally. `fault_shdn` becomes 1 at the next clock edge.
- R6: A switching cycle counts as "slow seen" if `oc_slow` was 1 on any clock edge from the edge after the previous strobe up to and including the current strobe edge. At the eighth consecutive "slow seen" cycle, `fault_shdn` becomes 1 at that strobe edge.
- R7: A cycle that is not "slow seen" resets the consecutive-cycle count to zero. Seven seen, one clear and seven more seen cause no fault.
- R8: Once `fault_shdn` is 1, it stays 1 while `enable` is high, whatever the other inputs do. During that time `gate_en` and `ss_active` are 0. Dropping `enable` clears it at the next edge.
- R9: Dropping and raising `enable` starts a fresh soft-start and clears the consecutive slow-cycle count.
- R10: A single-clock pulse of `oc_slow` anywhere inside a cycle makes that cycle "slow seen".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable; a low level clears a latched fault |
| cyc_start | input | 1 | One-clock strobe closing each switching cycle |
| oc_fast | input | 1 | High-level overcurrent comparator flag |
| oc_slow | input | 1 | Low-level overcurrent comparator flag |
| f_at_max | input | 1 | Frequency command at or above its ceiling |
| gate_en | output | 1 | Half-bridge gate drive permitted |
| fault_shdn | output | 1 | Latched overcurrent shutdown |
| ss_active | output | 1 | Soft-start running; forces the frequency command to maximum |

## Verification
A wrong consecutive-cycle count shows up as a `fault_shdn` edge that comes one or more strobes early or late, or not at all, in the eight-cycle sweep. A stale frequency-blank register shows as a wrong `gate_en` level on the first clock after a strobe, and on every clock until the next strobe. A wrong soft-start count moves the fall of `ss_active` away from strobe `SS_CYCLES`. A fault latch that leaks shows as `gate_en` or `ss_active` coming back while `enable` is still high.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } hbs_state_e;
endpackage

// File: rtl/hbs_slow_trip.sv
// Consecutive-cycle qualifier for the low-level overcurrent flag.
module hbs_slow_trip #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cyc_start,
  input  logic oc_slow,
  output logic trip
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          seen_now;

  // the strobe edge itself closes the window it belongs to
  assign seen_now = seen_q | oc_slow;
  assign trip     = !clear && cyc_start && seen_now && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cyc_start) begin
      seen_q <= 1'b0;
      if (!seen_now)      cnt_q <= '0;
      else if (!trip)     cnt_q <= cnt_q + 1'b1;
    end else if (oc_slow) begin
      seen_q <= 1'b1;
    end
  end

  // R7: a clean cycle drops the run length to zero
  p_clean_cycle_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cyc_start && !oc_slow && !seen_q) |=> (cnt_q == '0));

  // R10: a pulse between strobes is remembered until the strobe
  p_pulse_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cyc_start && oc_slow) |=> seen_q || clear);
endmodule

// File: rtl/hbs_ss_timer.sv
// Counts switching cycles of the soft-start interval.
module hbs_ss_timer #(
  parameter int CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cyc_start,
  output logic last
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  assign last = run && cyc_start && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || last) cnt_q <= '0;
    else if (cyc_start)    cnt_q <= cnt_q + 1'b1;
  end

  // R2: only strobes advance the interval
  p_count_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cyc_start) |=> $stable(cnt_q));
endmodule

// File: rtl/hbs_freq_blank.sv
// Whole-cycle gate suppression at the frequency ceiling.
module hbs_freq_blank (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cyc_start,
  input  logic f_at_max,
  output logic blank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blank <= 1'b0;
    else if (clear)     blank <= 1'b0;
    else if (cyc_start) blank <= f_at_max;
  end

  // R4: the decision only moves on a cycle boundary
  p_blank_whole_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cyc_start) |=> $stable(blank));
endmodule

// File: rtl/hb_guard.sv
module hb_guard
  import hbs_pkg::*;
#(
  parameter int SLOW_LIMIT = 8,
  parameter int SS_CYCLES  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cyc_start,
  input  logic oc_fast,
  input  logic oc_slow,
  input  logic f_at_max,
  output logic gate_en,
  output logic fault_shdn,
  output logic ss_active
);
  hbs_state_e st_q, st_d;
  logic live, slow_trip, ss_last, blank;

  assign live = (st_q == ST_SOFT) || (st_q == ST_RUN);

  hbs_slow_trip #(.LIMIT(SLOW_LIMIT)) u_slow (
    .clk(clk), .rst_n(rst_n), .clear(!live), .cyc_start(cyc_start),
    .oc_slow(oc_slow), .trip(slow_trip));

  hbs_ss_timer #(.CYCLES(SS_CYCLES)) u_ss (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_SOFT), .cyc_start(cyc_start),
    .last(ss_last));

  hbs_freq_blank u_blank (
    .clk(clk), .rst_n(rst_n), .clear(!live), .cyc_start(cyc_start),
    .f_at_max(f_at_max), .blank(blank));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:   if (enable) st_d = ST_SOFT;
      ST_SOFT, ST_RUN: begin
        if (!enable)                    st_d = ST_OFF;
        else if (oc_fast || slow_trip)  st_d = ST_FAULT;
        else if (st_q == ST_SOFT && ss_last) st_d = ST_RUN;
      end
      ST_FAULT: if (!enable) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // fast trip bypasses every register on the way to the gates
  assign gate_en    = ((st_q == ST_SOFT) || (st_q == ST_RUN && !blank)) && !oc_fast;
  assign fault_shdn = (st_q == ST_FAULT);
  assign ss_active  = (st_q == ST_SOFT);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fault_shdn && !ss_active && !gate_en));

  p_ss_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && enable) |=> (ss_active && !fault_shdn));

  p_fast_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && enable && oc_fast) |=> fault_shdn);

  p_slow_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && enable && slow_trip) |=> fault_shdn);

  p_fault_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_shdn && enable) |=> fault_shdn);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_shdn |-> (!gate_en && !ss_active));
endmodule

// File: tb/hb_guard_bench.sv
module hb_guard_bench;
  localparam int SS = 32;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n, enable, cyc_start, oc_fast, oc_slow, f_at_max;
  logic gate_en, fault_shdn, ss_active;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  hb_guard #(.SLOW_LIMIT(LIM), .SS_CYCLES(SS)) u_hb_guard (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_start(cyc_start),
    .oc_fast(oc_fast), .oc_slow(oc_slow), .f_at_max(f_at_max),
    .gate_en(gate_en), .fault_shdn(fault_shdn), .ss_active(ss_active));

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 60000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cycles, 60000);
      summary();
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one switching cycle of four clocks; strobe on the last
  task automatic run_cycles(input int n, input bit slow);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < 4; i++) begin
        cyc_start = (i == 3);
        oc_slow   = slow && (i == 1);
        tick();
      end
    end
    cyc_start = 1'b0;
    oc_slow   = 1'b0;
  endtask

  task automatic reenable();
    enable = 1'b0; tick();
    enable = 1'b1; tick();
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; cyc_start = 1'b0;
    oc_fast = 1'b0; oc_slow = 1'b0; f_at_max = 1'b0;
    tick(); tick();
    chk(gate_en, 1'b0, "R1 gate in reset");
    chk(fault_shdn, 1'b0, "R1 fault in reset");
    chk(ss_active, 1'b0, "R1 ss in reset");
    rst_n = 1'b1;
    oc_fast = 1'b1; oc_slow = 1'b1;
    run_cycles(2, 1'b1);
    oc_fast = 1'b0;
    chk(fault_shdn, 1'b0, "R1 no fault while disabled");
    chk(gate_en, 1'b0, "R1 gate while disabled");

    // soft-start with the ceiling flag held high
    enable = 1'b1; f_at_max = 1'b1; tick();
    chk(ss_active, 1'b1, "R2 ss after enable");
    chk(gate_en, 1'b1, "R2 gate in soft-start");
    for (int c = 0; c < SS; c++) begin
      for (int i = 0; i < 4; i++) begin
        cyc_start = (i == 3);
        tick();
        if (!(c == SS - 1 && i == 3)) begin
          chk(gate_en, 1'b1, "R3 ceiling ignored in soft-start");
          chk(ss_active, 1'b1, "R2 ss still running");
        end
      end
    end
    cyc_start = 1'b0;
    chk(ss_active, 1'b0, "R2 ss ends after SS strobes");
    chk(gate_en, 1'b0, "R4 blanked by ceiling at last strobe");

    // R4 sweep: value at the strobe decides, noise between strobes ignored
    begin
      bit prev = 1'b1;
      for (int p = 0; p < 16; p++) begin
        bit b = ((p % 3) == 0) || (p == 7) || (p == 11);
        for (int i = 0; i < 4; i++) begin
          cyc_start = (i == 3);
          f_at_max  = (i == 3) ? b : ~b;
          tick();
          chk(gate_en, (i == 3) ? ~b : ~prev, "R4 whole-cycle gating");
        end
        prev = b;
      end
    end
    cyc_start = 1'b0; f_at_max = 1'b0;
    run_cycles(1, 1'b0);
    chk(gate_en, 1'b1, "R4 resumes at strobe after ceiling clears");

    // slow overcurrent run lengths
    run_cycles(LIM - 1, 1'b1);
    chk(fault_shdn, 1'b0, "R6 no trip after seven");
    chk(gate_en, 1'b1, "R6 gate still on after seven");
    run_cycles(1, 1'b0);
    run_cycles(LIM - 1, 1'b1);
    chk(fault_shdn, 1'b0, "R7 clean cycle restarted count");
    run_cycles(1, 1'b1);
    chk(fault_shdn, 1'b1, "R6 trip at eighth strobe");
    chk(gate_en, 1'b0, "R8 gate off in fault");
    chk(ss_active, 1'b0, "R8 ss off in fault");

    // latch holds against all stimulus
    oc_fast = 1'b1; f_at_max = 1'b1;
    run_cycles(3, 1'b1);
    oc_fast = 1'b0; f_at_max = 1'b0;
    run_cycles(2, 1'b0);
    chk(fault_shdn, 1'b1, "R8 fault latched");
    chk(gate_en, 1'b0, "R8 gate stays off");
    enable = 1'b0; tick();
    chk(fault_shdn, 1'b0, "R8 cleared by enable low");
    chk(ss_active, 1'b0, "R1 ss off while disabled");
    enable = 1'b1; tick();
    chk(ss_active, 1'b1, "R9 fresh soft-start");
    chk(gate_en, 1'b1, "R9 gate on in soft-start");

    // counter cleared by re-enable
    run_cycles(LIM - 1, 1'b1);
    reenable();
    run_cycles(1, 1'b1);
    run_cycles(1, 1'b0);
    chk(fault_shdn, 1'b0, "R9 slow count cleared by re-enable");
    chk(ss_active, 1'b1, "R9 soft-start restarted");

    // fast trip during soft-start
    tick();
    oc_fast = 1'b1; #1;
    chk(gate_en, 1'b0, "R5 gate off same clock in soft-start");
    chk(fault_shdn, 1'b0, "R5 fault waits for edge");
    tick();
    oc_fast = 1'b0; #1;
    chk(fault_shdn, 1'b1, "R5 fault after edge in soft-start");
    chk(gate_en, 1'b0, "R8 gate off after fast trip");

    // full soft-start then fast trip while running
    reenable();
    run_cycles(SS - 1, 1'b0);
    chk(ss_active, 1'b1, "R2 ss before final strobe");
    run_cycles(1, 1'b0);
    chk(ss_active, 1'b0, "R2 ss over after SS strobes");
    chk(gate_en, 1'b1, "R4 gate on in run");
    tick();
    oc_fast = 1'b1; #1;
    chk(gate_en, 1'b0, "R5 gate off same clock in run");
    tick();
    oc_fast = 1'b0; #1;
    chk(fault_shdn, 1'b1, "R5 fault after edge in run");

    // single pulse per cycle trips from a clean start
    reenable();
    run_cycles(SS, 1'b0);
    run_cycles(LIM, 1'b1);
    chk(fault_shdn, 1'b1, "R10 single-clock pulses count");

    summary();
  end
endmodule